// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-side register set of a four-channel DMA controller. A host reaches it over a narrow I/O port bus with a 4-bit offset, an 8-bit write data bus, an 8-bit read data bus and separate read and write strobes. For each channel it holds a base and a current address and a base and a current count, all 16 bits wide. It also holds a mask bit, a mode field and a software request bit per channel. It keeps one command byte, a set of terminal-count flags and a shared low/high byte pointer. Every 16-bit value is reached as two byte accesses to one offset: low byte first, then high byte.

A transfer engine next to the block reads each channel's mask, mode, current address and current count. It sends back a one-cycle step pulse per channel, which moves the address by one and lowers the count by one, and a terminal-count pulse per channel. The host bus is a plain strobe interface with no back-pressure. Each strobe is taken in the cycle it is high. Read data is registered and appears one cycle after the read strobe. There is no valid/ready stream at this block's edge.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are set, the byte pointer selects the low byte, modes, addresses, counts, requests, command and terminal-count flags are zero, and rd_data is 0x00.
- R2: Offsets 0 to 7 address the channels: channel n's address is at offset 2n and its count at offset 2n+1. Each read or write at these offsets transfers the low byte when the pointer is clear and the high byte when it is set, then toggles the pointer. A write of any value to offset 0xC clears the pointer.
- R3: A write to a base address or base count byte also loads the whole current register from the updated base. A read at offsets 0 to 7 returns a byte of the current register. With no write and no engine pulse, current address and count hold their values.
- R4: A write to offset 0xA sets channel wdata[1:0]'s mask bit to wdata[2]. A write to offset 0xE clears all mask bits. A write to offset 0xF loads all four mask bits from wdata[3:0], bit n for channel n.
- R5: A write to offset 0xB stores wdata[7:2] as the mode of channel wdata[1:0], visible on ch_mode bits [6n+5:6n]. Field bit 2 (wdata[4]) enables auto-initialise. Field bit 3 (wdata[5]) makes the address count down.
- R6: A step pulse on a channel raises its current address by one, or lowers it by one when field bit 3 is set, and lowers its current count by one. A count programmed as N−1 therefore reads 0xFFFF after N steps.
- R7: A terminal-count pulse on a channel with auto-initialise reloads the current address and count from the base values and leaves the mask alone. Without auto-initialise it sets the channel's mask bit.
- R8: A read at offset 8 returns the request bits in [7:4] and the terminal-count flags in [3:0]. A terminal-count pulse sets the channel's flag. The status read clears all flags after returning them.
- R9: A write to offset 9 sets channel wdata[1:0]'s request bit to wdata[2]. A terminal-count pulse on a channel clears that channel's request bit. ch_req shows the request bits.
- R10: A write to offset 0xD sets all mask bits and clears the pointer, command, requests and terminal-count flags. Modes, addresses and counts are kept.
- R11: A write to offset 8 stores the command byte on ctl_cmd. A read at offset 0xD returns 0x00 and does not move the pointer.
- R12: rd_data is updated at the clock edge that samples rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| rd_data | output | 8 | Registered read data |
| eng_step | input | 4 | Per-channel step pulse from the engine |
| eng_tc | input | 4 | Per-channel terminal-count pulse from the engine |
| ch_mask | output | 4 | Per-channel mask, 1 = disabled |
| ch_mode | output | 24 | Per-channel 6-bit mode fields |
| ch_req | output | 4 | Per-channel software request bits |
| ctl_cmd | output | 8 | Command byte |
| cur_addr | output | 64 | Current address, channel n at [16n+15:16n] |
| cur_cnt | output | 64 | Current count, channel n at [16n+15:16n] |

## Verification
Every register and every output pin updates at the clock edge that samples the write strobe or the engine pulse. The bench drives stimulus at the falling edge and compares all outputs against its model at the next falling edge. Read data appears at that same edge, and the pointer and flag side effects of the read show up in the next access. Each bus access or pulse is therefore one full cycle, followed at once by a complete comparison. No result is sampled near a rising edge.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int NCH   = 4;
  localparam int CHW   = 2;
  localparam int BYTEW = 8;
  localparam int REGW  = 16;
  localparam int MODEW = 6;
  localparam int OFFW  = 4;
  localparam int MB_AUTO = 2;
  localparam int MB_DEC  = 3;

  typedef enum logic [OFFW-1:0] {
    OFF_CMD     = 4'h8,
    OFF_REQ     = 4'h9,
    OFF_SMASK   = 4'hA,
    OFF_MODE    = 4'hB,
    OFF_CLRPTR  = 4'hC,
    OFF_MCLR    = 4'hD,
    OFF_CLRMASK = 4'hE,
    OFF_ALLMASK = 4'hF
  } ctl_off_e;
endpackage

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BYTEW-1:0] wdata,
  input  logic             ld_addr,
  input  logic             ld_cnt,
  input  logic             hi_sel,
  input  logic             step,
  input  logic             tc,
  input  logic             autoinit,
  input  logic             dec_dir,
  output logic [REGW-1:0]  cur_a,
  output logic [REGW-1:0]  cur_c
);
  logic [REGW-1:0] base_a, base_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0;
      cur_a  <= '0;
    end else if (ld_addr) begin
      if (hi_sel) begin
        base_a[REGW-1:BYTEW] <= wdata;
        cur_a <= {wdata, base_a[BYTEW-1:0]};
      end else begin
        base_a[BYTEW-1:0] <= wdata;
        cur_a <= {base_a[REGW-1:BYTEW], wdata};
      end
    end else if (tc && autoinit) begin
      cur_a <= base_a;
    end else if (step) begin
      cur_a <= dec_dir ? cur_a - 1'b1 : cur_a + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_c <= '0;
      cur_c  <= '0;
    end else if (ld_cnt) begin
      if (hi_sel) begin
        base_c[REGW-1:BYTEW] <= wdata;
        cur_c <= {wdata, base_c[BYTEW-1:0]};
      end else begin
        base_c[BYTEW-1:0] <= wdata;
        cur_c <= {base_c[REGW-1:BYTEW], wdata};
      end
    end else if (tc && autoinit) begin
      cur_c <= base_c;
    end else if (step) begin
      cur_c <= cur_c - 1'b1;
    end
  end
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl
  import dma_rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OFFW-1:0]      addr,
  input  logic [BYTEW-1:0]     wdata,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [NCH-1:0]       eng_tc,
  output logic                 ptr_hi,
  output logic [NCH-1:0]       ld_addr,
  output logic [NCH-1:0]       ld_cnt,
  output logic [NCH-1:0]       mask_q,
  output logic [NCH*MODEW-1:0] mode_q,
  output logic [NCH-1:0]       req_q,
  output logic [BYTEW-1:0]     cmd_q,
  output logic [NCH-1:0]       tc_q
);
  logic             chan_acc;
  logic [CHW-1:0]   acc_ch, dat_ch;
  logic [NCH-1:0]   auto_vec, mask_d, req_d, tc_d;
  logic             mclr;

  assign chan_acc = (addr[OFFW-1] == 1'b0);
  assign acc_ch   = addr[CHW:1];
  assign dat_ch   = wdata[CHW-1:0];
  assign mclr     = wr && (addr == OFF_MCLR);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign ld_addr[i]  = wr && chan_acc && (acc_ch == i) && !addr[0];
    assign ld_cnt[i]   = wr && chan_acc && (acc_ch == i) &&  addr[0];
    assign auto_vec[i] = mode_q[i*MODEW + MB_AUTO];
  end

  always_comb begin
    mask_d = mask_q | (eng_tc & ~auto_vec);
    if (wr) begin
      case (addr)
        OFF_SMASK:   mask_d[dat_ch] = wdata[2];
        OFF_MCLR:    mask_d = '1;
        OFF_CLRMASK: mask_d = '0;
        OFF_ALLMASK: mask_d = wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    req_d = req_q & ~eng_tc;
    if (wr && addr == OFF_REQ) req_d[dat_ch] = wdata[2];
    if (mclr) req_d = '0;
  end

  always_comb begin
    tc_d = ((rd && addr == OFF_CMD) ? '0 : tc_q) | eng_tc;
    if (mclr) tc_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_hi <= 1'b0;
      mask_q <= '1;
      mode_q <= '0;
      req_q  <= '0;
      cmd_q  <= '0;
      tc_q   <= '0;
    end else begin
      mask_q <= mask_d;
      req_q  <= req_d;
      tc_q   <= tc_d;
      if (mclr || (wr && addr == OFF_CLRPTR)) ptr_hi <= 1'b0;
      else if ((wr || rd) && chan_acc)        ptr_hi <= ~ptr_hi;
      if (mclr)                       cmd_q <= '0;
      else if (wr && addr == OFF_CMD) cmd_q <= wdata;
      if (wr && addr == OFF_MODE)
        mode_q[dat_ch*MODEW +: MODEW] <= wdata[BYTEW-1:CHW];
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OFFW-1:0]      bus_addr,
  input  logic [BYTEW-1:0]     bus_wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [BYTEW-1:0]     rd_data,
  input  logic [NCH-1:0]       eng_step,
  input  logic [NCH-1:0]       eng_tc,
  output logic [NCH-1:0]       ch_mask,
  output logic [NCH*MODEW-1:0] ch_mode,
  output logic [NCH-1:0]       ch_req,
  output logic [BYTEW-1:0]     ctl_cmd,
  output logic [NCH*REGW-1:0]  cur_addr,
  output logic [NCH*REGW-1:0]  cur_cnt
);
  logic            ptr_hi;
  logic [NCH-1:0]  ld_addr, ld_cnt, tc_flags;
  logic [REGW-1:0] ca [NCH];
  logic [REGW-1:0] cc [NCH];
  logic [REGW-1:0] rd_word;

  dma_rf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(wr_en), .rd(rd_en), .eng_tc(eng_tc), .ptr_hi(ptr_hi),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt), .mask_q(ch_mask), .mode_q(ch_mode),
    .req_q(ch_req), .cmd_q(ctl_cmd), .tc_q(tc_flags)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_rf_chan u_chan (
      .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
      .ld_addr(ld_addr[i]), .ld_cnt(ld_cnt[i]), .hi_sel(ptr_hi),
      .step(eng_step[i]), .tc(eng_tc[i]),
      .autoinit(ch_mode[i*MODEW + MB_AUTO]), .dec_dir(ch_mode[i*MODEW + MB_DEC]),
      .cur_a(ca[i]), .cur_c(cc[i])
    );
    assign cur_addr[i*REGW +: REGW] = ca[i];
    assign cur_cnt[i*REGW +: REGW]  = cc[i];
  end

  assign rd_word = bus_addr[0] ? cc[bus_addr[CHW:1]] : ca[bus_addr[CHW:1]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (!bus_addr[OFFW-1])        rd_data <= ptr_hi ? rd_word[REGW-1:BYTEW] : rd_word[BYTEW-1:0];
      else if (bus_addr == OFF_CMD) rd_data <= {ch_req, tc_flags};
      else                          rd_data <= '0;
    end
  end
endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk
  import dma_rf_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [OFFW-1:0]      bus_addr,
  input logic [BYTEW-1:0]     bus_wdata,
  input logic                 wr_en,
  input logic [NCH-1:0]       eng_step,
  input logic [NCH-1:0]       eng_tc,
  input logic [NCH-1:0]       ch_mask,
  input logic [NCH*MODEW-1:0] ch_mode,
  input logic [NCH-1:0]       ch_req,
  input logic [NCH*REGW-1:0]  cur_addr,
  input logic [NCH*REGW-1:0]  cur_cnt
);
  AST_CLRALL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_CLRMASK) |=> (ch_mask == '0)); // R4

  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_MCLR) |=> (ch_mask == '1 && ch_req == '0)); // R10

  AST_MODE_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_MODE && bus_wdata[1:0] == 2'd0)
      |=> (ch_mode[MODEW-1:0] == $past(bus_wdata[BYTEW-1:CHW]))); // R5

  AST_STEP_CNT0: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_step[0] && !eng_tc[0] && !wr_en)
      |=> (cur_cnt[REGW-1:0] == $past(cur_cnt[REGW-1:0]) - 16'd1)); // R6

  AST_TC_MASK0: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tc[0] && !ch_mode[MB_AUTO] && !(wr_en && (bus_addr == OFF_SMASK ||
      bus_addr == OFF_CLRMASK || bus_addr == OFF_ALLMASK))) |=> ch_mask[0]); // R7

  AST_TC_REQ0: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tc[0] && !(wr_en && (bus_addr == OFF_REQ))) |=> !ch_req[0]); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && eng_step == '0 && eng_tc == '0)
      |=> ($stable(cur_addr) && $stable(cur_cnt))); // R3
endmodule

bind dma_regfile dma_rf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .wr_en(wr_en), .eng_step(eng_step), .eng_tc(eng_tc), .ch_mask(ch_mask),
  .ch_mode(ch_mode), .ch_req(ch_req), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
);

// File: tb/sim_dma_regfile.sv
`timescale 1ns/1ps
module sim_dma_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [3:0]  eng_step = '0, eng_tc = '0;
  logic [3:0]  ch_mask, ch_req;
  logic [23:0] ch_mode;
  logic [7:0]  ctl_cmd;
  logic [63:0] cur_addr, cur_cnt;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_ba [4], m_ca [4], m_bc [4], m_cc [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_req, m_tc;
  logic [7:0]  m_cmd;
  bit          m_ff;

  always #10 clk = ~clk;

  dma_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .eng_step(eng_step),
    .eng_tc(eng_tc), .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_req(ch_req),
    .ctl_cmd(ctl_cmd), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_mode();
    logic [23:0] v;
    for (int c = 0; c < 4; c++) v[c*6 +: 6] = m_mode[c];
    return v;
  endfunction

  function automatic logic [63:0] pack16(input bit cnt);
    logic [63:0] v;
    for (int c = 0; c < 4; c++) v[c*16 +: 16] = cnt ? m_cc[c] : m_ca[c];
    return v;
  endfunction

  task automatic check_all(input string r);
    chk(ch_mask == m_mask, {r, " R4 mask"}, ch_mask, m_mask);
    chk(ch_req == m_req, {r, " R9 req"}, ch_req, m_req);
    chk(ch_mode == exp_mode(), {r, " R5 mode"}, ch_mode, exp_mode());
    chk(ctl_cmd == m_cmd, {r, " R11 cmd"}, ctl_cmd, m_cmd);
    chk(cur_addr == pack16(0), {r, " R3 addr"}, cur_addr, pack16(0));
    chk(cur_cnt == pack16(1), {r, " R3 cnt"}, cur_cnt, pack16(1));
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_ba[c] = 0; m_ca[c] = 0; m_bc[c] = 0; m_cc[c] = 0; m_mode[c] = 0;
    end
    m_mask = 4'hF; m_req = 0; m_tc = 0; m_cmd = 0; m_ff = 0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    int c;
    bus_addr = a; bus_wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    c = int'(d[1:0]);
    if (!a[3]) begin
      if (a[0]) begin
        if (m_ff) m_bc[a[2:1]][15:8] = d; else m_bc[a[2:1]][7:0] = d;
        m_cc[a[2:1]] = m_bc[a[2:1]];
      end else begin
        if (m_ff) m_ba[a[2:1]][15:8] = d; else m_ba[a[2:1]][7:0] = d;
        m_ca[a[2:1]] = m_ba[a[2:1]];
      end
      m_ff = !m_ff;
    end else begin
      case (a)
        4'h8: m_cmd = d;
        4'h9: m_req[c] = d[2];
        4'hA: m_mask[c] = d[2];
        4'hB: m_mode[c] = d[7:2];
        4'hC: m_ff = 0;
        4'hD: begin m_mask = 4'hF; m_ff = 0; m_cmd = 0; m_tc = 0; m_req = 0; end
        4'hE: m_mask = 4'h0;
        default: m_mask = d[3:0];
      endcase
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, input string r);
    logic [15:0] v;
    logic [7:0]  e;
    if (!a[3]) begin
      v = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
      e = m_ff ? v[15:8] : v[7:0];
      m_ff = !m_ff;
    end else if (a == 4'h8) begin
      e = {m_req, m_tc};
      m_tc = 0;
    end else e = 8'h00;
    bus_addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == e, {r, " R12 rd_data"}, rd_data, e);
  endtask

  task automatic pulse(input logic [3:0] st, input logic [3:0] tc);
    eng_step = st; eng_tc = tc;
    @(posedge clk); @(negedge clk);
    eng_step = 0; eng_tc = 0;
    for (int c = 0; c < 4; c++) begin
      if (tc[c] && m_mode[c][2]) begin
        m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c];
      end else if (st[c]) begin
        m_ca[c] = m_mode[c][3] ? m_ca[c] - 16'd1 : m_ca[c] + 16'd1;
        m_cc[c] = m_cc[c] - 16'd1;
      end
      if (tc[c]) begin
        m_tc[c] = 1; m_req[c] = 0;
        if (!m_mode[c][2]) m_mask[c] = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    bus_rd(4'h8, "R1 status");

    // R2 R3: program channel 1, read back through pointer
    bus_wr(4'h2, 8'h34); bus_wr(4'h2, 8'h12);
    bus_wr(4'h3, 8'h02); bus_wr(4'h3, 8'h00);
    chk(cur_addr[31:16] == 16'h1234, "R2 addr ch1", cur_addr[31:16], 16'h1234);
    bus_rd(4'h2, "R2 lo"); bus_rd(4'h2, "R2 hi");
    bus_wr(4'h2, 8'hAA); bus_wr(4'hC, 8'h77); bus_wr(4'h2, 8'h55);
    chk(cur_addr[31:16] == 16'h1255, "R2 clear pointer", cur_addr[31:16], 16'h1255);
    check_all("R2");
    bus_wr(4'hC, 8'h00);

    // R6 R7 R8: three transfers ending at terminal count
    bus_wr(4'hA, 8'h01); bus_wr(4'hB, 8'h45);
    pulse(4'b0010, 0); pulse(4'b0010, 0); pulse(4'b0010, 4'b0010);
    chk(cur_cnt[31:16] == 16'hFFFF, "R6 wrap count", cur_cnt[31:16], 16'hFFFF);
    chk(ch_mask[1] == 1'b1, "R7 mask at tc", ch_mask, 4'hF);
    check_all("R6");
    bus_rd(4'h8, "R8 status set"); bus_rd(4'h8, "R8 status cleared");

    // R7 autoinit on channel 2, R9 request cleared by tc
    bus_wr(4'hB, 8'h56); bus_wr(4'hA, 8'h02);
    bus_wr(4'h4, 8'hF0); bus_wr(4'h4, 8'h0F); bus_wr(4'h5, 8'h10); bus_wr(4'h5, 8'h00);
    bus_wr(4'h9, 8'h06);
    bus_rd(4'h8, "R9 request in status");
    pulse(4'b0100, 0); pulse(4'b0100, 0);
    check_all("R6 ch2");
    pulse(4'b0100, 4'b0100);
    chk(cur_addr[47:32] == 16'h0FF0, "R7 reload addr", cur_addr[47:32], 16'h0FF0);
    chk(ch_mask[2] == 1'b0, "R7 autoinit keeps mask", ch_mask[2], 0);
    check_all("R7");

    // R5 R6 decrement on channel 3
    bus_wr(4'hB, 8'h67); bus_wr(4'h6, 8'h00); bus_wr(4'h6, 8'h00);
    pulse(4'b1000, 0);
    chk(cur_addr[63:48] == 16'hFFFF, "R6 address down", cur_addr[63:48], 16'hFFFF);
    check_all("R5");

    // R4 R11 R10
    bus_wr(4'hF, 8'h05); check_all("R4 all");
    bus_wr(4'hE, 8'h00); check_all("R4 clear all");
    bus_wr(4'h8, 8'h5A); check_all("R11 cmd");
    bus_wr(4'h0, 8'h11);
    bus_rd(4'hD, "R11 temp");
    bus_wr(4'h0, 8'h22);
    chk(cur_addr[15:0] == 16'h2211, "R11 pointer kept", cur_addr[15:0], 16'h2211);
    bus_wr(4'h9, 8'h05); pulse(0, 4'b1000);
    bus_wr(4'h0, 8'h33);
    bus_wr(4'hD, 8'h00);
    check_all("R10 master clear");
    bus_rd(4'h8, "R10 status");
    bus_rd(4'h1, "R10 pointer low");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: bus_wr(4'($urandom_range(0, 7)), 8'($urandom));
        3: bus_wr(4'hB, 8'($urandom));
        4: bus_wr(4'($urandom_range(8, 15)), 8'($urandom));
        5, 6: pulse(4'($urandom), ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0);
        7: bus_rd(4'($urandom_range(0, 7)), "R2 random read");
        8: bus_rd(4'h8, "R8 random status");
        default: bus_wr(4'h9, 8'($urandom));
      endcase
      check_all("random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule